// File: doc/BRIEF.md
# PCI Target Termination Controller

This block produces the target-side handshake of a 32-bit PCI target once an address decoder upstream has claimed a transaction. It drives the active-low devsel_n, trdy_n and stop_n bus signals through the data phases. It takes three active-low requests from a local back-end: ready, disconnect and abort. From them it chooses one of four endings: a normal completion, a disconnect that still moves one data word, a disconnect that moves none, or a target abort.

The back-end asks for a disconnect when a burst would cross the end of its address window. It asks for an abort when the byte enables of a shared DWORD select bytes it does not own. The controller decides between the two disconnect forms by looking at how the ready and disconnect requests line up in time. It also gives the back-end a transfer strobe for every completed data phase, and keeps a sticky flag that records an issued abort.

Top module: `tgt_term_ctrl`

## Requirements
- R1: While rst_n is low, devsel_n, trdy_n and stop_n are high, and be_xfer and abort_flag are 0.
- R2: A hit pulse while idle drives devsel_n low at the next rising edge, with trdy_n and stop_n still high.
- R3: While no termination is in progress, trdy_n takes, at each rising edge, the value that be_ready_n had just before that edge.
- R4: be_xfer is 1 exactly in the cycles where irdy_n and trdy_n are both low, which means a data phase completes at the following edge.
- R5: If disconnect is requested and no data phase has completed yet, including the one at this edge, and be_ready_n is low, then stop_n and trdy_n both go low at the same edge (disconnect with data). Exactly one data phase then completes.
- R6: If disconnect is requested and at least one data phase has completed, counting one that completes at this edge, then stop_n goes low and trdy_n goes high at that edge (disconnect without data).
- R7: A disconnect request made before any data phase has completed, while be_ready_n is high, is held. stop_n stays high until be_ready_n goes low.
- R8: An abort request during the data phases drives devsel_n high, trdy_n high and stop_n low at the next edge, and sets abort_flag. When abort and disconnect are requested together, the abort wins.
- R9: Once stop_n is low it stays low while frame_n is low. At the first edge that samples frame_n high, devsel_n, trdy_n and stop_n all go high together and the block becomes idle.
- R10: Without stop, an edge that samples frame_n high while be_xfer is 1 drives devsel_n and trdy_n high and returns the block to idle.
- R11: abort_flag stays 1 until an edge that samples abort_clr high clears it. If an abort is issued at that same edge, the flag stays set.
- R12: When a disconnect with data is under way, trdy_n goes high at the edge after the data phase completes, while stop_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | One-cycle claim pulse from the address decoder |
| frame_n | input | 1 | Master frame, active low |
| irdy_n | input | 1 | Master ready, active low |
| be_ready_n | input | 1 | Back-end ready to move a word, active low |
| be_disc_n | input | 1 | Back-end disconnect request, active low |
| be_abort_n | input | 1 | Back-end abort request, active low |
| abort_clr | input | 1 | Write-one-to-clear strobe for abort_flag |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| be_xfer | output | 1 | Data phase completes at the next edge |
| abort_flag | output | 1 | Sticky target-abort status |

## Verification
The bench sweeps the cycle at which ready arrives against the cycle at which disconnect arrives. For each pair it works out the ending and the number of completed phases with arithmetic. This catches a design that picks the wrong disconnect form when the two requests coincide or are one cycle apart, and catches one that lets a second word through after a disconnect with data. Separate runs check an abort that coincides with a disconnect, and an abort that coincides with a flag clear. A design that got the priority or the set-over-clear rule wrong would show the disconnect pattern, or lose the status bit. A normal completion and a trdy_n that follows ready back and forth check the plain data path.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP} tt_state_e;
  typedef enum logic [1:0] {TM_CONT, TM_ABORT, TM_DISC_DATA, TM_DISC_NODATA} tt_term_e;

  // a bus data phase completes on an edge where both ready lines are low
  function automatic logic phase_fire(logic irdy_n, logic trdy_n);
    return !irdy_n && !trdy_n;
  endfunction

  // termination choice: abort first, then disconnect form by phase history
  function automatic tt_term_e pick_term(logic abort_req, logic disc_req,
                                         logic done_now, logic ready_req);
    if (abort_req)                  return TM_ABORT;
    else if (disc_req && done_now)  return TM_DISC_NODATA;
    else if (disc_req && ready_req) return TM_DISC_DATA;
    else                            return TM_CONT;
  endfunction
endpackage

// File: rtl/tt_phase_track.sv
module tt_phase_track
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_data,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic disc_now,
  output logic xfer,
  output logic seen,
  output logic done_now,
  output logic disc_req
);
  logic disc_pend;

  assign xfer     = phase_fire(irdy_n, trdy_n);
  assign done_now = seen | xfer;
  assign disc_req = disc_now | disc_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      disc_pend <= 1'b0;
    end else if (start) begin
      seen      <= 1'b0;
      disc_pend <= 1'b0;
    end else begin
      if (xfer) seen <= 1'b1;
      if (in_data && disc_now) disc_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/tt_status.sv
module tt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tt_seq.sv
module tt_seq
  import tt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  logic      frame_n,
  input  logic      ready_req,
  input  logic      abort_req,
  input  logic      disc_req,
  input  logic      done_now,
  input  logic      xfer,
  output logic      devsel_n,
  output logic      trdy_n,
  output logic      stop_n,
  output tt_state_e state,
  output logic      abort_issue
);
  tt_state_e state_nx;
  logic      devsel_nx, trdy_nx, stop_nx;
  tt_term_e  term;

  assign term        = pick_term(abort_req, disc_req, done_now, ready_req);
  assign abort_issue = (state == ST_DATA) && (term == TM_ABORT);

  always_comb begin
    state_nx  = state;
    devsel_nx = devsel_n;
    trdy_nx   = trdy_n;
    stop_nx   = stop_n;
    unique case (state)
      ST_IDLE: if (hit) begin
        state_nx  = ST_DATA;
        devsel_nx = 1'b0;
        trdy_nx   = 1'b1;
        stop_nx   = 1'b1;
      end
      ST_DATA: begin
        unique case (term)
          TM_ABORT: begin
            state_nx = ST_STOP; devsel_nx = 1'b1; trdy_nx = 1'b1; stop_nx = 1'b0;
          end
          TM_DISC_DATA: begin
            state_nx = ST_STOP; trdy_nx = 1'b0; stop_nx = 1'b0;
          end
          TM_DISC_NODATA: begin
            state_nx = ST_STOP; trdy_nx = 1'b1; stop_nx = 1'b0;
          end
          default: begin
            if (frame_n && xfer) begin
              state_nx = ST_IDLE; devsel_nx = 1'b1; trdy_nx = 1'b1;
            end else begin
              trdy_nx = !ready_req;
            end
          end
        endcase
      end
      ST_STOP: begin
        if (frame_n) begin
          state_nx = ST_IDLE; devsel_nx = 1'b1; trdy_nx = 1'b1; stop_nx = 1'b1;
        end else if (xfer) begin
          trdy_nx = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
    end else begin
      state    <= state_nx;
      devsel_n <= devsel_nx;
      trdy_n   <= trdy_nx;
      stop_n   <= stop_nx;
    end
  end
endmodule

// File: rtl/tgt_term_ctrl.sv
module tgt_term_ctrl
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic be_ready_n,
  input  logic be_disc_n,
  input  logic be_abort_n,
  input  logic abort_clr,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic be_xfer,
  output logic abort_flag
);
  tt_state_e state;
  logic      start, in_data;
  logic      phase_seen, done_now, disc_req, abort_issue;

  assign start   = (state == ST_IDLE) && hit;
  assign in_data = (state == ST_DATA);

  tt_phase_track u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_data  (in_data),
    .irdy_n   (irdy_n),
    .trdy_n   (trdy_n),
    .disc_now (!be_disc_n),
    .xfer     (be_xfer),
    .seen     (phase_seen),
    .done_now (done_now),
    .disc_req (disc_req)
  );

  tt_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit         (hit),
    .frame_n     (frame_n),
    .ready_req   (!be_ready_n),
    .abort_req   (!be_abort_n),
    .disc_req    (disc_req),
    .done_now    (done_now),
    .xfer        (be_xfer),
    .devsel_n    (devsel_n),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .state       (state),
    .abort_issue (abort_issue)
  );

  tt_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (abort_issue),
    .clr   (abort_clr),
    .flag  (abort_flag)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic abort_flag,
  input logic abort_clr,
  input logic seen
);
  p_hold_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && frame_n) |=> (stop_n && trdy_n && devsel_n));
  p_abort_trdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && devsel_n) |-> trdy_n);
  p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_n) && devsel_n) |-> abort_flag);
  p_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_n) && !devsel_n && trdy_n) |-> seen);
  p_single_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !trdy_n && !irdy_n) |=> trdy_n);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !abort_clr) |=> abort_flag);
  p_trdy_claimed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);
endmodule

bind tgt_term_ctrl tt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .irdy_n     (irdy_n),
  .devsel_n   (devsel_n),
  .trdy_n     (trdy_n),
  .stop_n     (stop_n),
  .abort_flag (abort_flag),
  .abort_clr  (abort_clr),
  .seen       (phase_seen)
);

// File: tb/tgt_term_ctrl_bench.sv
`timescale 1ns/1ps
module tgt_term_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 1'b0, frame_n = 1'b1, irdy_n = 1'b1;
  logic be_ready_n = 1'b1, be_disc_n = 1'b1, be_abort_n = 1'b1, abort_clr = 1'b0;
  logic devsel_n, trdy_n, stop_n, be_xfer, abort_flag;
  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  tgt_term_ctrl u_tgt_term_ctrl (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    hit = 0; frame_n = 1; irdy_n = 1;
    be_ready_n = 1; be_disc_n = 1; be_abort_n = 1; abort_clr = 0;
  endtask

  task automatic claim();
    hit = 1; frame_n = 0; step(); hit = 0;
    chk("R2 devsel_n", devsel_n, 0);
    chk("R2 trdy_n", trdy_n, 1);
    chk("R2 stop_n", stop_n, 1);
  endtask

  // ready from cycle r, disconnect from cycle q, master always ready
  task automatic run_case(int r, int q);
    int t, nodata, exp_ph, cnt;
    t = (q > r) ? q : r;
    nodata = (q > r) ? 1 : 0;
    exp_ph = nodata ? (q - r) : 1;
    cnt = 0;
    claim();
    for (int c = 1; c <= t + 3; c++) begin
      be_ready_n = (c >= r) ? 1'b0 : 1'b1;
      be_disc_n  = (c >= q) ? 1'b0 : 1'b1;
      irdy_n = 0;
      frame_n = (c == t + 3) ? 1'b1 : 1'b0;
      #1;
      cnt += int'(be_xfer);
      step();
      if (c < t) begin
        chk("R7 stop_n held off", stop_n, 1);
        chk("R3 trdy_n follows ready", trdy_n, (c >= r) ? 0 : 1);
      end else if (c == t) begin
        chk(nodata ? "R6 stop_n" : "R5 stop_n", stop_n, 0);
        chk(nodata ? "R6 trdy_n" : "R5 trdy_n", trdy_n, nodata);
        chk("R9 devsel_n during stop", devsel_n, 0);
      end else if (c == t + 2) begin
        chk("R12 trdy_n released", trdy_n, 1);
        chk("R9 stop_n held", stop_n, 0);
      end else if (c == t + 3) begin
        chk("R9 release", {devsel_n, trdy_n, stop_n}, 7);
      end
    end
    chk(nodata ? "R6 R4 phase count" : "R5 R4 phase count", cnt, exp_ph);
    idle_inputs();
    step();
  endtask

  initial begin
    idle_inputs();
    @(negedge clk);
    chk("R1 outputs", {devsel_n, trdy_n, stop_n}, 7);
    chk("R1 strobe flag", {be_xfer, abort_flag}, 0);
    @(negedge clk);
    rst_n = 1;
    step();

    for (int r = 1; r <= 3; r++)
      for (int q = 1; q <= 4; q++)
        run_case(r, q);

    // R3 toggling ready with master not ready; R4 no strobe
    claim();
    be_ready_n = 0; step();
    chk("R3 trdy_n low", trdy_n, 0);
    #1 chk("R4 no strobe irdy high", be_xfer, 0);
    be_ready_n = 1; step();
    chk("R3 trdy_n high", trdy_n, 1);
    // R10 normal completion
    be_ready_n = 0; irdy_n = 0; step();
    #1 chk("R4 strobe", be_xfer, 1);
    frame_n = 1; step();
    chk("R10 end", {devsel_n, trdy_n, stop_n}, 7);
    idle_inputs(); step();
    #1 chk("R10 idle strobe", be_xfer, 0);

    // R8 abort wins over disconnect
    claim();
    be_ready_n = 0; irdy_n = 0; step();
    be_abort_n = 0; be_disc_n = 0; step();
    chk("R8 abort pattern", {devsel_n, trdy_n, stop_n}, 6);
    chk("R8 flag", abort_flag, 1);
    be_abort_n = 1; be_disc_n = 1; frame_n = 1; step();
    chk("R9 release after abort", {devsel_n, trdy_n, stop_n}, 7);
    idle_inputs(); step(); step();
    chk("R11 sticky", abort_flag, 1);
    abort_clr = 1; step(); abort_clr = 0;
    chk("R11 cleared", abort_flag, 0);

    // R11 set wins over clear at same edge
    claim();
    be_abort_n = 0; abort_clr = 1; step();
    abort_clr = 0; be_abort_n = 1;
    chk("R11 set over clear", abort_flag, 1);
    chk("R8 abort before phase", {devsel_n, trdy_n, stop_n}, 6);
    frame_n = 1; step();
    idle_inputs(); step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule